// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Block

This block is the software-visible face of a small LCD controller. A 32-bit register port reaches six word registers at byte offsets 0x00 through 0x14: control, three panel timing words, a read-only status word and a subpanel word. The decoded control and geometry fields are driven as plain outputs to a separate frame sequencer. That sequencer reports frame completion, palette load completion and synchronisation loss with single-cycle pulses, which the block keeps as sticky status flags and folds into one level interrupt.

The register port has no handshake. A write is accepted in any cycle where `wr_en` is high. `rdata` is a combinational function of `addr` while `rd_en` is high and is zero otherwise. There is no streaming data path, so no valid/ready interface is present. Every pin is a plain control or status signal, and nothing stalls.

Unimplemented bits of some registers read back as fixed ones. Panel width and height are taken from a 10-bit field holding the size minus one. Synchronisation loss interrupts without any mask.

Top module: `lcdc_regs`

## Requirements
- R1: After reset, every control field is 0 and every flag is 0. The outputs `irq`, `en_change`, `addr_err`, `width` and `height` are 0. Control reads 0xFE000C34, timing 0 and timing 1 read 0x000003FF, and status reads 0.
- R2: A write to offset 0x00 loads four fields: load mode from bits 21:20, TFT from bit 7, interrupt mask from bits 4:3, and mono from bit 1. It also keeps the written bits under 0x01CFF300. The read value ORs together the kept bits, 0xFE000C34, every field at its write position, and TFT copied again into bit 23. New values are visible after the next rising clock edge.
- R3: A write to 0x04 sets `width` to bits 9:0 plus one and stores bits 31:10. A read returns the stored upper bits, with (width-1) in bits 9:0, ORed with 0x0000000F.
- R4: A write to 0x08 sets `height` to bits 9:0 plus one and stores bits 31:10. A read returns the stored upper bits with (height-1) in bits 9:0.
- R5: Offset 0x0C stores the full written word and reads it back with bits 31:26 forced to one.
- R6: Status at 0x10 reads palette-done in bit 6, sync-error in bit 2 and frame-done in bit 0. Writes to it change nothing.
- R7: Offset 0x14 stores the written word ANDed with 0xA1FFFFFF and drives it on `subpanel`.
- R8: `irq` is high in the cycle after any of these conditions holds: frame-done with mask bit 0 set; palette-done with mask bit 1 set; or sync-error, whatever the mask. Otherwise it is low in that cycle.
- R9: A control write whose bit 0 differs from the current enable updates enable and pulses `en_change` for exactly the next cycle. A control write that leaves enable unchanged gives no pulse.
- R10: When enable goes from 1 to 0, sync-error is cleared. Frame-done is set unless the load mode written in that same write equals 1.
- R11: When enable goes from 0 to 1, frame-done and palette-done are cleared. Sync-error is kept.
- R12: A pulse on `set_frame_done`, `set_palette_done` or `set_sync_err` sets its flag at the next edge. In the same cycle, a clear caused by an enable change takes precedence over the pulse for that flag.
- R13: A read or write at any offset other than the six listed offsets returns 0 on read, changes no state, and makes `addr_err` high for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| addr_err | output | 1 | One-cycle pulse after an access to an unlisted offset |
| irq | output | 1 | Registered level interrupt |
| load_mode | output | 2 | Loading mode field |
| tft | output | 1 | Active-matrix panel select |
| mono | output | 1 | Monochrome select |
| enable | output | 1 | Controller enable |
| width | output | 11 | Line width in pixels (0 after reset) |
| height | output | 11 | Frame height in lines (0 after reset) |
| subpanel | output | 32 | Masked subpanel word |
| en_change | output | 1 | Pulse: enable changed value |
| set_frame_done | input | 1 | Sequencer pulse: frame finished |
| set_palette_done | input | 1 | Sequencer pulse: palette loaded |
| set_sync_err | input | 1 | Sequencer pulse: synchronisation lost |

## Verification
Two functions can act in the same cycle. One is a sequencer pulse setting a flag. The other is a control write that toggles enable and so clears or forces that same flag. The bench raises `set_palette_done` in the cycle of an enabling write, then reads status and expects palette-done to be clear. It also disables in load mode 1 while no frame pulse is present, and expects frame-done to stay clear and sync-error to be dropped.

// File: rtl/lcdc_pkg.sv
`timescale 1ns/1ps
package lcdc_pkg;
  localparam int DW   = 32;
  localparam int NREG = 6;
  localparam int NF   = 3;

  typedef enum logic [2:0] {
    RI_CTRL = 3'd0, RI_TIM0 = 3'd1, RI_TIM1 = 3'd2,
    RI_TIM2 = 3'd3, RI_STAT = 3'd4, RI_SUBP = 3'd5
  } reg_idx_e;

  // control bit positions
  localparam int CB_EN     = 0;
  localparam int CB_MONO   = 1;
  localparam int CB_IMASK  = 3;
  localparam int CB_TFT    = 7;
  localparam int CB_MODE   = 20;
  localparam int CB_TFT_RB = 23;

  // status bit positions
  localparam int SB_FRAME = 0;
  localparam int SB_SYNC  = 2;
  localparam int SB_PAL   = 6;

  // flag indices
  localparam int FL_FRAME = 0;
  localparam int FL_PAL   = 1;
  localparam int FL_SYNC  = 2;

  localparam logic [DW-1:0] CTRL_KEEP = 32'h01cf_f300;
  localparam logic [DW-1:0] CTRL_ONES = 32'hfe00_0c34;
  localparam logic [DW-1:0] TIM0_ONES = 32'h0000_000f;
  localparam logic [DW-1:0] TIM2_ONES = 32'hfc00_0000;
  localparam logic [DW-1:0] SUBP_MASK = 32'ha1ff_ffff;
  localparam logic [1:0]    MODE_NO_FRAME = 2'd1;

  typedef struct packed {
    logic [1:0] load_mode;
    logic       tft;
    logic [1:0] imask;
    logic       mono;
    logic       enable;
  } ctrl_t;
endpackage

// File: rtl/lcdc_addr_dec.sv
`timescale 1ns/1ps
module lcdc_addr_dec
  import lcdc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              access,
  output logic [NREG-1:0]   sel,
  output logic              bad
);
  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign sel[g] = (addr == ADDR_W'(g * 4));
  end
  assign bad = access && (sel == '0);
endmodule

// File: rtl/lcdc_flags.sv
`timescale 1ns/1ps
module lcdc_flags
  import lcdc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_frame,
  input  logic          set_pal,
  input  logic          set_sync,
  input  logic          ena_evt,
  input  logic          dis_evt,
  input  logic          dis_mark_frame,
  input  logic [1:0]    imask,
  output logic [NF-1:0] flag_q,
  output logic [DW-1:0] stat_word,
  output logic          irq
);
  logic [NF-1:0] set_v, clr_v, frc_v;

  assign set_v[FL_FRAME] = set_frame;
  assign set_v[FL_PAL]   = set_pal;
  assign set_v[FL_SYNC]  = set_sync;
  assign clr_v[FL_FRAME] = ena_evt;
  assign clr_v[FL_PAL]   = ena_evt;
  assign clr_v[FL_SYNC]  = dis_evt;
  assign frc_v[FL_FRAME] = dis_mark_frame;
  assign frc_v[FL_PAL]   = 1'b0;
  assign frc_v[FL_SYNC]  = 1'b0;

  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)        flag_q[g] <= 1'b0;
      else if (frc_v[g]) flag_q[g] <= 1'b1;
      else if (clr_v[g]) flag_q[g] <= 1'b0;
      else if (set_v[g]) flag_q[g] <= 1'b1;
    end
  end

  always_comb begin
    stat_word           = '0;
    stat_word[SB_FRAME] = flag_q[FL_FRAME];
    stat_word[SB_SYNC]  = flag_q[FL_SYNC];
    stat_word[SB_PAL]   = flag_q[FL_PAL];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else irq <= (flag_q[FL_FRAME] & imask[0]) |
                (flag_q[FL_PAL]   & imask[1]) |
                 flag_q[FL_SYNC];
  end
endmodule

// File: rtl/lcdc_regfile.sv
`timescale 1ns/1ps
module lcdc_regfile
  import lcdc_pkg::*;
#(
  parameter int FIELD_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [NREG-1:0]  sel,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    stat_word,
  output logic [DW-1:0]    rdata,
  output ctrl_t            ctrl,
  output logic [FIELD_W:0] width,
  output logic [FIELD_W:0] height,
  output logic [DW-1:0]    subpanel,
  output logic             ena_evt,
  output logic             dis_evt,
  output logic             dis_mark_frame,
  output logic             en_change
);
  localparam int HI_W = DW - FIELD_W;
  localparam logic [FIELD_W:0] ONE = (FIELD_W+1)'(1);

  logic [DW-1:0]    keep_q, tim2_q;
  logic [HI_W-1:0]  tim0_hi_q, tim1_hi_q;
  logic [FIELD_W:0] w_m1, h_m1;
  logic [DW-1:0]    rd_ctrl, rd_mux;
  logic             wr_ctrl;

  assign wr_ctrl        = wr_en & sel[RI_CTRL];
  assign ena_evt        = wr_ctrl &  wdata[CB_EN] & ~ctrl.enable;
  assign dis_evt        = wr_ctrl & ~wdata[CB_EN] &  ctrl.enable;
  assign dis_mark_frame = dis_evt && (wdata[CB_MODE +: 2] != MODE_NO_FRAME);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      keep_q    <= '0;
      tim0_hi_q <= '0;
      tim1_hi_q <= '0;
      width     <= '0;
      height    <= '0;
      tim2_q    <= '0;
      subpanel  <= '0;
      en_change <= 1'b0;
    end else begin
      en_change <= ena_evt | dis_evt;
      if (wr_ctrl) begin
        ctrl.load_mode <= wdata[CB_MODE +: 2];
        ctrl.tft       <= wdata[CB_TFT];
        ctrl.imask     <= wdata[CB_IMASK +: 2];
        ctrl.mono      <= wdata[CB_MONO];
        ctrl.enable    <= wdata[CB_EN];
        keep_q         <= wdata & CTRL_KEEP;
      end
      if (wr_en && sel[RI_TIM0]) begin
        tim0_hi_q <= wdata[DW-1:FIELD_W];
        width     <= {1'b0, wdata[FIELD_W-1:0]} + ONE;
      end
      if (wr_en && sel[RI_TIM1]) begin
        tim1_hi_q <= wdata[DW-1:FIELD_W];
        height    <= {1'b0, wdata[FIELD_W-1:0]} + ONE;
      end
      if (wr_en && sel[RI_TIM2]) tim2_q   <= wdata;
      if (wr_en && sel[RI_SUBP]) subpanel <= wdata & SUBP_MASK;
    end
  end

  assign w_m1 = width - ONE;
  assign h_m1 = height - ONE;

  always_comb begin
    rd_ctrl = CTRL_ONES | keep_q;
    rd_ctrl[CB_EN]         = rd_ctrl[CB_EN]   | ctrl.enable;
    rd_ctrl[CB_MONO]       = rd_ctrl[CB_MONO] | ctrl.mono;
    rd_ctrl[CB_IMASK +: 2] = rd_ctrl[CB_IMASK +: 2] | ctrl.imask;
    rd_ctrl[CB_TFT]        = rd_ctrl[CB_TFT]  | ctrl.tft;
    rd_ctrl[CB_MODE +: 2]  = rd_ctrl[CB_MODE +: 2] | ctrl.load_mode;
    rd_ctrl[CB_TFT_RB]     = rd_ctrl[CB_TFT_RB] | ctrl.tft;
  end

  always_comb begin
    rd_mux = '0;
    if (sel[RI_CTRL]) rd_mux = rd_ctrl;
    if (sel[RI_TIM0]) rd_mux = {tim0_hi_q, w_m1[FIELD_W-1:0]} | TIM0_ONES;
    if (sel[RI_TIM1]) rd_mux = {tim1_hi_q, h_m1[FIELD_W-1:0]};
    if (sel[RI_TIM2]) rd_mux = tim2_q | TIM2_ONES;
    if (sel[RI_STAT]) rd_mux = stat_word;
    if (sel[RI_SUBP]) rd_mux = subpanel;
  end

  assign rdata = rd_en ? rd_mux : '0;
endmodule

// File: rtl/lcdc_regs.sv
`timescale 1ns/1ps
module lcdc_regs
  import lcdc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int FIELD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              addr_err,
  output logic              irq,
  output logic [1:0]        load_mode,
  output logic              tft,
  output logic              mono,
  output logic              enable,
  output logic [FIELD_W:0]  width,
  output logic [FIELD_W:0]  height,
  output logic [DW-1:0]     subpanel,
  output logic              en_change,
  input  logic              set_frame_done,
  input  logic              set_palette_done,
  input  logic              set_sync_err
);
  logic [NREG-1:0] sel;
  logic            bad;
  logic [DW-1:0]   stat_word;
  logic [NF-1:0]   flag_q;
  logic            ena_evt, dis_evt, dis_mark_frame;
  logic            flag_frame, flag_pal, flag_sync;
  logic [1:0]      imask;
  ctrl_t           ctrl_s;

  lcdc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .access(wr_en | rd_en), .sel(sel), .bad(bad)
  );

  lcdc_regfile #(.FIELD_W(FIELD_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .sel(sel),
    .wdata(wdata), .stat_word(stat_word), .rdata(rdata), .ctrl(ctrl_s),
    .width(width), .height(height), .subpanel(subpanel),
    .ena_evt(ena_evt), .dis_evt(dis_evt), .dis_mark_frame(dis_mark_frame),
    .en_change(en_change)
  );

  lcdc_flags u_fl (
    .clk(clk), .rst_n(rst_n),
    .set_frame(set_frame_done), .set_pal(set_palette_done),
    .set_sync(set_sync_err), .ena_evt(ena_evt), .dis_evt(dis_evt),
    .dis_mark_frame(dis_mark_frame), .imask(ctrl_s.imask),
    .flag_q(flag_q), .stat_word(stat_word), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) addr_err <= 1'b0;
    else        addr_err <= bad;
  end

  assign load_mode  = ctrl_s.load_mode;
  assign tft        = ctrl_s.tft;
  assign mono       = ctrl_s.mono;
  assign enable     = ctrl_s.enable;
  assign imask      = ctrl_s.imask;
  assign flag_frame = flag_q[FL_FRAME];
  assign flag_pal   = flag_q[FL_PAL];
  assign flag_sync  = flag_q[FL_SYNC];
endmodule

// File: rtl/lcdc_regs_chk.sv
`timescale 1ns/1ps
module lcdc_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              enable,
  input logic [1:0]        imask,
  input logic              flag_frame,
  input logic              flag_pal,
  input logic              flag_sync,
  input logic              irq,
  input logic              en_change,
  input logic              addr_err
);
  logic ctrl_wr, off_list;
  assign ctrl_wr  = wr_en && (addr == '0);
  assign off_list = (addr[1:0] != 2'b00) || (addr > ADDR_W'(20));

  a_r8_sync_raises: assert property (@(posedge clk) disable iff (!rst_n)
    flag_sync |=> irq);
  a_r8_quiet_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_sync && !(flag_frame && imask[0]) && !(flag_pal && imask[1])) |=> !irq);
  a_r9_notify: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && (wdata[0] != enable)) |=> en_change);
  a_r9_no_notify: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_wr && (wdata[0] != enable)) |=> !en_change);
  a_r10_drop_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && enable && !wdata[0]) |=> !flag_sync);
  a_r10_mark_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && enable && !wdata[0] && wdata[21:20] != 2'd1) |=> flag_frame);
  a_r11_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !enable && wdata[0]) |=> (!flag_frame && !flag_pal));
  a_r13_bad_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && off_list) |=> addr_err);
  a_r13_no_false_err: assert property (@(posedge clk) disable iff (!rst_n)
    !((wr_en || rd_en) && off_list) |=> !addr_err);
endmodule

bind lcdc_regs lcdc_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .enable(enable), .imask(imask), .flag_frame(flag_frame),
  .flag_pal(flag_pal), .flag_sync(flag_sync), .irq(irq),
  .en_change(en_change), .addr_err(addr_err)
);

// File: tb/sim_lcdc_regs.sv
`timescale 1ns/1ps
module sim_lcdc_regs;
  localparam time TCK = 20ns;
  localparam int  NV  = 9;

  // {addr, write data, expected read}
  localparam logic [71:0] VEC [NV] = '{
    {8'h00, 32'h0030_0096, 32'hfeb0_0cb6},  // R2 fields, TFT mirror
    {8'h00, 32'h01cf_f300, 32'hffcf_ff34},  // R2 kept bits
    {8'h04, 32'habcd_e130, 32'habcd_e13f},  // R3
    {8'h08, 32'h0000_1def, 32'h0000_1def},  // R4
    {8'h0c, 32'h1234_5678, 32'hfe34_5678},  // R5
    {8'h14, 32'hffff_ffff, 32'ha1ff_ffff},  // R7
    {8'h14, 32'h5e00_0001, 32'h0000_0001},  // R7 masked
    {8'h10, 32'hffff_ffff, 32'h0000_0000},  // R6 write ignored
    {8'h18, 32'hffff_ffff, 32'h0000_0000}   // R13 unlisted offset
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, subpanel;
  logic        addr_err, irq, tft, mono, enable, en_change;
  logic [1:0]  load_mode;
  logic [10:0] width, height;
  logic        set_frame_done = 1'b0, set_palette_done = 1'b0, set_sync_err = 1'b0;
  int          checks = 0, errors = 0;
  logic [31:0] rv;

  always #(TCK/2) clk = ~clk;

  lcdc_regs u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .addr_err(addr_err), .irq(irq),
    .load_mode(load_mode), .tft(tft), .mono(mono), .enable(enable),
    .width(width), .height(height), .subpanel(subpanel),
    .en_change(en_change), .set_frame_done(set_frame_done),
    .set_palette_done(set_palette_done), .set_sync_err(set_sync_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access cycle with optional sequencer pulses {sync, palette, frame}
  task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d,
                     input logic [2:0] p);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d;
    {set_sync_err, set_palette_done, set_frame_done} = p;
    @(negedge clk);
    wr_en = 1'b0;
    {set_sync_err, set_palette_done, set_frame_done} = 3'b000;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(TCK * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 width", 32'(width), 0);
    chk("R1 height", 32'(height), 0);
    rd(8'h00, rv); chk("R1 ctrl", rv, 32'hfe00_0c34);
    rd(8'h04, rv); chk("R1 tim0", rv, 32'h0000_03ff);
    rd(8'h08, rv); chk("R1 tim1", rv, 32'h0000_03ff);
    rd(8'h10, rv); chk("R1 status", rv, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      cyc(1'b1, VEC[i][71:64], VEC[i][63:32], 3'b000);
      rd(VEC[i][71:64], rv);
      chk($sformatf("table row %0d", i), rv, VEC[i][31:0]);
    end
    chk("R3 width", 32'(width), 32'd305);
    chk("R4 height", 32'(height), 32'h1f0);
    chk("R7 subpanel pin", subpanel, 32'h0000_0001);

    // R12 frame pulse; R8 masked off
    cyc(1'b0, 8'h00, 0, 3'b001);
    rd(8'h10, rv); chk("R12 frame set", rv, 32'h1);
    step(); chk("R8 masked", 32'(irq), 0);
    // R8 enable mask bit 0: irq one cycle after mask lands
    cyc(1'b1, 8'h00, 32'h0000_0008, 3'b000);
    chk("R8 latency", 32'(irq), 0);
    step(); chk("R8 frame irq", 32'(irq), 1);
    // R8 mask off, palette pulse, then mask bit 1
    cyc(1'b1, 8'h00, 32'h0, 3'b010);
    step(); chk("R8 all masked", 32'(irq), 0);
    cyc(1'b1, 8'h00, 32'h0000_0010, 3'b000);
    step(); chk("R8 palette irq", 32'(irq), 1);
    // R8 sync error with no mask
    cyc(1'b1, 8'h00, 32'h0, 3'b100);
    step(); chk("R8 sync irq", 32'(irq), 1);
    rd(8'h10, rv); chk("R6 status layout", rv, 32'h45);

    // R11/R12 collision: enabling write with palette pulse
    cyc(1'b1, 8'h00, 32'h1, 3'b010);
    chk("R9 en_change", 32'(en_change), 1);
    chk("R9 enable", 32'(enable), 1);
    rd(8'h10, rv); chk("R11 R12 collision", rv, 32'h04);
    step(); chk("R9 pulse width", 32'(en_change), 0);
    cyc(1'b1, 8'h00, 32'h1, 3'b000);
    chk("R9 no change", 32'(en_change), 0);

    // R10 disable in load mode 1
    cyc(1'b1, 8'h00, 32'h0010_0000, 3'b000);
    chk("R10 notify", 32'(en_change), 1);
    rd(8'h10, rv); chk("R10 mode1 disable", rv, 32'h00);
    chk("R2 load_mode pin", 32'(load_mode), 1);
    // R10 disable in mode 0
    cyc(1'b1, 8'h00, 32'h1, 3'b000);
    cyc(1'b1, 8'h00, 32'h0, 3'b000);
    rd(8'h10, rv); chk("R10 mode0 disable", rv, 32'h01);

    // R13 bad write pulse and no state change
    cyc(1'b1, 8'h18, 32'hffff_ffff, 3'b000);
    chk("R13 err pulse", 32'(addr_err), 1);
    rd(8'h00, rv); chk("R13 ctrl unchanged", rv, 32'hfe00_0c34);
    step(); chk("R13 err one cycle", 32'(addr_err), 0);
    rd(8'h02, rv); chk("R13 unaligned read", rv, 0);
    cyc(1'b0, 8'h00, 0, 3'b000);
    chk("R13 good access no err", 32'(addr_err), 0);

    // R1 reset mid-run
    rst_n = 1'b0;
    step(); step();
    chk("R1 width again", 32'(width), 0);
    chk("R1 irq again", 32'(irq), 0);
    rd(8'h14, rv); chk("R1 subpanel", rv, 0);
    rd(8'h10, rv); chk("R1 status again", rv, 0);
    rst_n = 1'b1;
    finish_run();
  end
endmodule